// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block steers a chip between five operating modes and owns the enables that gate the CPU clock and each peripheral clock. Software picks a mode, a per-peripheral clock mask and an interrupt-enable mask through a small word-addressed register port. The block drives a CPU clock enable, one clock enable per peripheral, a select that moves the system clock off the PLL onto a low-frequency source, and a request to cut chip power. The PLL, the clock gating cells and the power switches sit outside and only follow these controls.

Each low-power mode has its own set of events that end it. Any wake-up returns the chip to normal mode, and the mode register reads back as normal afterwards. Software can also fire a fixed-length reset pulse at any subset of peripherals.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode reads 0 (normal), the CPU clock enable is 1, every peripheral clock enable is 1, PLL bypass is 0, the power-off request is 0 and no peripheral reset is active.
- R2: A write to address 0 sets the mode from bits [2:0] (0 normal, 1 slow, 2 idle, 3 stop, 4 power-down) at the clock edge that ends the write, and all outputs show the new mode from that same edge; codes 5 to 7 leave the mode unchanged.
- R3: In normal and slow modes the CPU clock enable is 1 and the peripheral enables equal the mask; PLL bypass is 1 in slow mode only.
- R4: In idle mode the CPU clock enable is 0 and the peripheral enables still equal the mask.
- R5: In stop mode the CPU enable and every peripheral enable are 0.
- R6: In power-down mode the power-off request is 1 and all clock enables are 0; in every other mode the request is 0.
- R7: A write to address 1 sets the peripheral clock mask, bit i driving peripheral i, with effect from the edge that ends the write.
- R8: In idle mode, an interrupt input whose enable bit (address 3) is set, or the external interrupt, returns the mode to normal at the next edge; a masked interrupt has no effect.
- R9: In stop mode only the external interrupt returns the mode to normal; internal interrupts, host and key inputs have no effect.
- R10: In power-down mode only the host or key wake input returns the mode to normal; interrupts have no effect.
- R11: A mode write that lands in the same cycle as a wake event valid for the requested mode is cancelled and the mode becomes normal.
- R12: Writing address 2 with bit i set drives peripheral reset i high for exactly 4 cycles from the edge ending the write; zero bits have no effect, and a new write during a pulse restarts the count.
- R13: The read port returns, combinationally from the read address, the mode (address 0), the clock mask (1), the active reset bits (2) and the interrupt-enable mask (3), zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Register read data |
| irq_i | input | NUM_IRQ | Internal interrupt lines |
| ext_irq_i | input | 1 | External interrupt |
| host_wake_i | input | 1 | Wake request from an external host |
| key_wake_i | input | 1 | Wake request from a key input |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | NUM_PERIPH | Peripheral clock enables |
| pll_bypass_o | output | 1 | Selects the low-frequency clock instead of the PLL |
| power_off_req_o | output | 1 | Request to remove chip power |
| periph_rst_o | output | NUM_PERIPH | Peripheral reset pulses |

## Verification
The hardest case to reach is a wake event arriving in the very cycle that a mode write asks for the matching low-power mode, since in a real system the CPU stops before any wake could follow its own write. The bench holds the write strobe and the wake input together for one cycle, for both power-down with a host wake and idle with an external interrupt, and expects normal mode afterwards. It also drives wake inputs that belong to a different mode while the block sits in stop and power-down, so that only the correct wake source ends each mode.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int NUM_PERIPH = 8,
  parameter int NUM_IRQ    = 8,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [1:0]            rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [NUM_IRQ-1:0]    irq_i,
  input  logic                  ext_irq_i,
  input  logic                  host_wake_i,
  input  logic                  key_wake_i,
  output logic                  cpu_clk_en_o,
  output logic [NUM_PERIPH-1:0] periph_clk_en_o,
  output logic                  pll_bypass_o,
  output logic                  power_off_req_o,
  output logic [NUM_PERIPH-1:0] periph_rst_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] RST_LOAD = CW'(RST_CYCLES);
  localparam logic [2:0] M_NORM = 3'd0, M_SLOW = 3'd1, M_IDLE = 3'd2,
                         M_STOP = 3'd3, M_PDWN = 3'd4;

  logic [2:0]            mode_q, mode_d, target;
  logic [NUM_PERIPH-1:0] clken_q, clken_d;
  logic [NUM_IRQ-1:0]    irq_en_q;
  logic                  wr_mode, wr_rst, wake_hit;
  logic                  unused_bits;

  assign unused_bits = &{1'b0, wr_data};
  assign wr_mode  = wr_en && wr_addr == 2'd0 && wr_data[2:0] <= M_PDWN;
  assign wr_rst   = wr_en && wr_addr == 2'd2;
  assign target   = wr_mode ? wr_data[2:0] : mode_q;
  assign wake_hit = (target == M_IDLE && (|(irq_i & irq_en_q) || ext_irq_i))
                 || (target == M_STOP && ext_irq_i)
                 || (target == M_PDWN && (host_wake_i || key_wake_i));
  assign mode_d   = wake_hit ? M_NORM : target;
  assign clken_d  = (wr_en && wr_addr == 2'd1) ? wr_data[NUM_PERIPH-1:0] : clken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q          <= M_NORM;
      clken_q         <= '1;
      irq_en_q        <= '0;
      cpu_clk_en_o    <= 1'b1;
      periph_clk_en_o <= '1;
      pll_bypass_o    <= 1'b0;
      power_off_req_o <= 1'b0;
    end else begin
      mode_q          <= mode_d;
      clken_q         <= clken_d;
      if (wr_en && wr_addr == 2'd3) irq_en_q <= wr_data[NUM_IRQ-1:0];
      cpu_clk_en_o    <= mode_d == M_NORM || mode_d == M_SLOW;
      periph_clk_en_o <= (mode_d <= M_IDLE) ? clken_d : '0;
      pll_bypass_o    <= mode_d == M_SLOW;
      power_off_req_o <= mode_d == M_PDWN;
    end
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_prst
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (wr_rst && wr_data[i]) cnt_q <= RST_LOAD;
      else if (cnt_q != '0)          cnt_q <= cnt_q - 1'b1;
    end
    assign periph_rst_o[i] = cnt_q != '0;

    assert_rst_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(periph_rst_o[i]) |-> $past(wr_rst && wr_data[i]));
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      2'd0: rd_data[2:0]           = mode_q;
      2'd1: rd_data[NUM_PERIPH-1:0] = clken_q;
      2'd2: rd_data[NUM_PERIPH-1:0] = periph_rst_o;
      default: rd_data[NUM_IRQ-1:0] = irq_en_q;
    endcase
  end

  assert_slow_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pll_bypass_o |-> cpu_clk_en_o && mode_q == M_SLOW);
  assert_idle_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == M_IDLE |-> !cpu_clk_en_o && periph_clk_en_o == clken_q);
  assert_stop_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == M_STOP |-> !cpu_clk_en_o && periph_clk_en_o == '0 && !power_off_req_o);
  assert_pdwn_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    power_off_req_o |-> !cpu_clk_en_o && periph_clk_en_o == '0);
  assert_bad_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SLOW && wr_en && wr_addr == 2'd0 && wr_data[2:0] > M_PDWN) |=> mode_q == M_SLOW);
  assert_idle_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_IDLE && !wr_en && |(irq_i & irq_en_q)) |=> mode_q == M_NORM);
  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STOP && !wr_en && !ext_irq_i) |=> mode_q == M_STOP);
  assert_pdwn_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PDWN && !wr_en && !host_wake_i && !key_wake_i) |=> power_off_req_o);
  assert_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data[2:0] == M_PDWN && (host_wake_i || key_wake_i))
      |=> mode_q == M_NORM && !power_off_req_o);
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, ext = 1'b0, host = 1'b0, key = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [3:0]  irq = '0;
  logic        cpu_en, byp, poff;
  logic [7:0]  pen, prst;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.NUM_PERIPH(8), .NUM_IRQ(4), .DATA_W(32), .RST_CYCLES(4)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_i(irq), .ext_irq_i(ext),
    .host_wake_i(host), .key_wake_i(key), .cpu_clk_en_o(cpu_en),
    .periph_clk_en_o(pen), .pll_bypass_o(byp), .power_off_req_o(poff),
    .periph_rst_o(prst));

  // {we, addr, data, irq, ext, host, key | mode, cpu, periph, bypass, off | tag}
  localparam logic [35:0] VEC [18] = '{
    {1'b1, 2'd1, 8'h5A, 4'h0, 3'b000, 3'd0, 1'b1, 8'h5A, 1'b0, 1'b0, 4'd7},
    {1'b1, 2'd0, 8'h01, 4'h0, 3'b000, 3'd1, 1'b1, 8'h5A, 1'b1, 1'b0, 4'd3},
    {1'b1, 2'd0, 8'h00, 4'h0, 3'b000, 3'd0, 1'b1, 8'h5A, 1'b0, 1'b0, 4'd3},
    {1'b1, 2'd3, 8'h03, 4'h0, 3'b000, 3'd0, 1'b1, 8'h5A, 1'b0, 1'b0, 4'd8},
    {1'b1, 2'd0, 8'h02, 4'h0, 3'b000, 3'd2, 1'b0, 8'h5A, 1'b0, 1'b0, 4'd4},
    {1'b0, 2'd0, 8'h00, 4'h4, 3'b000, 3'd2, 1'b0, 8'h5A, 1'b0, 1'b0, 4'd8},
    {1'b0, 2'd0, 8'h00, 4'h2, 3'b000, 3'd0, 1'b1, 8'h5A, 1'b0, 1'b0, 4'd8},
    {1'b1, 2'd0, 8'h03, 4'h0, 3'b000, 3'd3, 1'b0, 8'h00, 1'b0, 1'b0, 4'd5},
    {1'b0, 2'd0, 8'h00, 4'h1, 3'b011, 3'd3, 1'b0, 8'h00, 1'b0, 1'b0, 4'd9},
    {1'b0, 2'd0, 8'h00, 4'h0, 3'b100, 3'd0, 1'b1, 8'h5A, 1'b0, 1'b0, 4'd9},
    {1'b1, 2'd0, 8'h04, 4'h0, 3'b000, 3'd4, 1'b0, 8'h00, 1'b0, 1'b1, 4'd6},
    {1'b0, 2'd0, 8'h00, 4'hF, 3'b100, 3'd4, 1'b0, 8'h00, 1'b0, 1'b1, 4'd10},
    {1'b0, 2'd0, 8'h00, 4'h0, 3'b001, 3'd0, 1'b1, 8'h5A, 1'b0, 1'b0, 4'd10},
    {1'b1, 2'd0, 8'h04, 4'h0, 3'b010, 3'd0, 1'b1, 8'h5A, 1'b0, 1'b0, 4'd11},
    {1'b1, 2'd0, 8'h07, 4'h0, 3'b000, 3'd0, 1'b1, 8'h5A, 1'b0, 1'b0, 4'd2},
    {1'b1, 2'd0, 8'h02, 4'h0, 3'b100, 3'd0, 1'b1, 8'h5A, 1'b0, 1'b0, 4'd11},
    {1'b1, 2'd0, 8'h04, 4'h0, 3'b000, 3'd4, 1'b0, 8'h00, 1'b0, 1'b1, 4'd6},
    {1'b0, 2'd0, 8'h00, 4'h0, 3'b010, 3'd0, 1'b1, 8'h5A, 1'b0, 1'b0, 4'd10}
  };

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd2: return "R2";   4'd3: return "R3";   4'd4: return "R4";
      4'd5: return "R5";   4'd6: return "R6";   4'd7: return "R7";
      4'd8: return "R8";   4'd9: return "R9";   4'd10: return "R10";
      4'd11: return "R11"; default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    check("R1", {20'd0, rd_data[2:0], cpu_en, pen, byp, poff, 1'b0},
                {20'd0, 3'd0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0});
    check("R1", {24'd0, prst}, 32'd0);
    rd_addr = 2'd3;
    #1 check("R13", rd_data, 32'd0);
    rd_addr = 2'd0;

    for (int k = 0; k < 18; k++) begin
      {wr_en, wr_addr, wr_data[7:0], irq, ext, host, key} = VEC[k][35:18];
      tick();
      check(tag(VEC[k][3:0]), {18'd0, rd_data[2:0], cpu_en, pen, byp, poff},
                              {18'd0, VEC[k][17:4]});
    end
    {wr_en, wr_addr, wr_data, irq, ext, host, key} = '0;

    // R13 readback of mask and interrupt enables
    rd_addr = 2'd1;
    #1 check("R13", rd_data, 32'h5A);
    rd_addr = 2'd3;
    #1 check("R13", rd_data, 32'h3);

    // R12 pulse length, untouched bits
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h81;
    tick();
    wr_en = 1'b0; wr_data = '0;
    rd_addr = 2'd2;
    #1 check("R12", rd_data, 32'h81);
    for (int c = 1; c < 4; c++) begin
      tick();
      check("R12", {24'd0, prst}, 32'h81);
    end
    tick();
    check("R12", {24'd0, prst}, 32'h0);

    // R12 restart on rewrite
    wr_en = 1'b1; wr_data = 32'h01;
    tick();
    wr_en = 1'b0; wr_data = '0;
    tick();
    wr_en = 1'b1; wr_data = 32'h01;
    tick();
    wr_en = 1'b0; wr_data = '0;
    for (int c = 0; c < 3; c++) begin
      tick();
      check("R12", {24'd0, prst}, 32'h01);
    end
    tick();
    check("R12", {24'd0, prst}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule